// File: doc/BRIEF.md
# Serial Transmitter with Holding Register

This block turns parallel words into asynchronous serial frames. A write strobe places one word in a holding register. After a short synchronization delay, and as soon as the shift stage is idle, the word passes into the shift stage. The shift stage then drives a frame made of a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and a high stop period. The stop period lasts one, one and a half or two bit times.

Bit timing comes from an external tick at sixteen times the baud rate. Each bit lasts 16 ticks, and a one-and-a-half stop period lasts 24 ticks. The holding-register-empty flag goes high when the word leaves the holding register, not when its frame ends. Software can therefore queue the next word while the current one is still on the line. The frame settings are captured when a word moves into the shift stage.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, the serial line is high, the empty flag is 1 and the busy flag is 0.
- R2: A frame opens with a start bit held low for 16 ticks. Data bits follow least significant bit first, each held for 16 ticks.
- R3: The word-length code sets the number of data bits: code 0 sends 5, code 1 sends 6, code 2 sends 7 and code 3 sends 8. Data bits above the configured length are not sent.
- R4: The parity code selects the parity bit: 0 or 3 sends no parity bit, 1 sends even parity and 2 sends odd parity. Even parity makes the total count of ones over the data bits and the parity bit even; odd parity makes it odd. Only the configured data bits enter the parity.
- R5: The stop code sets the stop period, during which the line is high: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks. The line stays high while the block is not busy.
- R6: A write is accepted only while the empty flag is 1. A write while the flag is 0 changes neither the stored word nor the flags.
- R7: If the shift stage is idle, an accepted word moves into it SYNC_CYCLES+1 clock cycles after the write. In that same cycle the empty flag rises, busy rises and the start bit begins. Ticks seen in that cycle do not count.
- R8: A word that is ready while a frame is on the line waits in the holding register. It is loaded in the clock cycle after busy falls.
- R9: Word length, parity and stop settings are sampled when a word is loaded. Changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Word to send |
| word_len_i | input | 2 | Data length code (5 + code bits) |
| stop_sel_i | input | 2 | Stop period code |
| parity_i | input | 2 | Parity code |
| tick_i | input | 1 | One-cycle pulse at 16x the baud rate |
| txd_o | output | 1 | Serial output line |
| thr_empty_o | output | 1 | Holding register empty |
| busy_o | output | 1 | Frame in progress |

## Verification
Two functions can fall in the same cycle. First, the end of a stop period can coincide with a word that has been waiting in the holding register. Second, a baud tick can arrive in the very cycle a word is loaded. The bench writes a new word as soon as the empty flag rises, while the tick runs every fourth clock, so load cycles land at every phase of the tick. A behavioural model holds the frame as a queue of line levels and tick lengths. On every clock it judges the line level, the empty flag and busy, which exposes a frame that starts one cycle late or a tick that is wrongly counted.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF2 = 2'd3
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_prep.sv
module uart_tx_prep #(
  parameter int DATA_W = 8,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        word_len_i,
  input  logic [1:0]        parity_i,
  output logic [DATA_W-1:0] data_o,
  output logic [NB_W-1:0]   nbits_o,
  output logic              par_en_o,
  output logic              par_bit_o
);
  import uart_tx_pkg::*;

  assign nbits_o = NB_W'(DATA_W - 3) + NB_W'(word_len_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign data_o[i] = data_i[i] & (NB_W'(i) < nbits_o);
  end

  always_comb begin
    par_en_o  = 1'b0;
    par_bit_o = 1'b0;
    unique case (parity_e'(parity_i))
      PAR_EVEN: begin par_en_o = 1'b1; par_bit_o = ^data_o;  end
      PAR_ODD:  begin par_en_o = 1'b1; par_bit_o = ~^data_o; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/uart_tx_thr.sv
module uart_tx_thr #(
  parameter int DATA_W      = 8,
  parameter int SYNC_CYCLES = 2,
  localparam int SCNT_W     = (SYNC_CYCLES < 1) ? 1 : $clog2(SYNC_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              shift_busy_i,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic [SCNT_W-1:0] sync_q;
  logic              ready;

  assign ready   = full_q && (sync_q == SCNT_W'(SYNC_CYCLES));
  assign load_o  = ready && !shift_busy_i;
  assign data_o  = data_q;
  assign empty_o = !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      sync_q <= '0;
    end else if (load_o) begin
      full_q <= 1'b0;
      sync_q <= '0;
    end else if (wr_en_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
      sync_q <= '0;
    end else if (full_q && !ready) begin
      sync_q <= sync_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int NB_W         = $clog2(DATA_W + 1),
  localparam int LIM_W        = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  input  logic [1:0]        stop_sel_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              busy_o
);
  import uart_tx_pkg::*;

  localparam int HALF = TICKS_PER_BIT / 2;

  tx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [NB_W-1:0]   left_q;
  logic [LIM_W-1:0]  cnt_q, stop_lim_q, lim, stop_lim_d;
  logic              par_en_q, par_q, bit_end;

  always_comb begin
    unique case (stop_sel_i)
      2'd0:    stop_lim_d = LIM_W'(TICKS_PER_BIT);
      2'd1:    stop_lim_d = LIM_W'(TICKS_PER_BIT + HALF);
      default: stop_lim_d = LIM_W'(2 * TICKS_PER_BIT);
    endcase
  end

  assign lim     = (state_q == ST_STOP) ? stop_lim_q : LIM_W'(TICKS_PER_BIT);
  assign bit_end = tick_i && (cnt_q == lim - 1'b1);
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      left_q     <= '0;
      cnt_q      <= '0;
      stop_lim_q <= LIM_W'(TICKS_PER_BIT);
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
    end else if (load_i) begin
      state_q    <= ST_START;
      sh_q       <= data_i;
      left_q     <= nbits_i;
      cnt_q      <= '0;
      stop_lim_q <= stop_lim_d;
      par_en_q   <= par_en_i;
      par_q      <= par_bit_i;
    end else if (tick_i && busy_o) begin
      if (bit_end) begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
            if (left_q == NB_W'(1)) state_q <= par_en_q ? ST_PAR : ST_STOP;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_CYCLES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        word_len_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        parity_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              thr_empty_o,
  output logic              busy_o
);
  localparam int NB_W = $clog2(DATA_W + 1);

  logic              load, busy;
  logic [DATA_W-1:0] thr_data, prep_data;
  logic [NB_W-1:0]   nbits;
  logic              par_en, par_bit;

  uart_tx_thr #(.DATA_W(DATA_W), .SYNC_CYCLES(SYNC_CYCLES)) u_thr (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .shift_busy_i(busy), .load_o(load), .data_o(thr_data), .empty_o(thr_empty_o)
  );

  uart_tx_prep #(.DATA_W(DATA_W)) u_prep (
    .data_i(thr_data), .word_len_i, .parity_i,
    .data_o(prep_data), .nbits_o(nbits), .par_en_o(par_en), .par_bit_o(par_bit)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .data_i(prep_data), .nbits_i(nbits),
    .par_en_i(par_en), .par_bit_i(par_bit), .stop_sel_i, .tick_i,
    .txd_o, .busy_o(busy)
  );

  assign busy_o = busy;
endmodule

// File: rtl/uart_tx_hold_chk.sv
module uart_tx_hold_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic txd_o,
  input logic thr_empty_o,
  input logic busy_o
);
  // R5: line high when no frame
  a_r5_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  // R6: accepted write fills the register
  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && thr_empty_o) |=> !thr_empty_o);

  // R7: empty and busy rise together
  a_r7_empty_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_empty_o) |-> $rose(busy_o));

  // R2: frame opens low
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);

  // R5: frame closes on a high stop period
  a_r5_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(txd_o));
endmodule

bind uart_tx_hold uart_tx_hold_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .txd_o(txd_o), .thr_empty_o(thr_empty_o), .busy_o(busy_o)
);

// File: tb/uart_tx_hold_tb.sv
module uart_tx_hold_tb;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wl = 2'd3, st = 2'd0, par = 2'd0;
  logic       tick = 1'b0;
  logic       txd, empty, busy;

  int total = 0, bad = 0, cycles = 0, tdiv = 0;
  string cur_req = "R1";

  // behavioural model
  int   seg_lvl[$];
  int   seg_len[$];
  bit   m_full = 0;
  int   m_sync = 0;
  logic [7:0] m_data = '0;

  always #5 clk = ~clk;

  uart_tx_hold u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .word_len_i(wl), .stop_sel_i(st), .parity_i(par), .tick_i(tick),
    .txd_o(txd), .thr_empty_o(empty), .busy_o(busy)
  );

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
  end

  always @(posedge clk) begin
    bit busy_pre, load;
    int n, p;
    logic [7:0] md;
    if (!rst_n) begin
      seg_lvl.delete(); seg_len.delete();
      m_full = 0; m_sync = 0;
    end else begin
      busy_pre = seg_len.size() > 0;
      load = m_full && m_sync == SYNC && !busy_pre;
      if (busy_pre && tick) begin
        seg_len[0] = seg_len[0] - 1;
        if (seg_len[0] == 0) begin
          void'(seg_lvl.pop_front()); void'(seg_len.pop_front());
        end
      end
      if (load) begin
        n = 5 + int'(wl);
        md = 8'(m_data & ((1 << n) - 1));
        seg_lvl.push_back(0); seg_len.push_back(16);
        for (int i = 0; i < n; i++) begin
          seg_lvl.push_back(int'(md[i])); seg_len.push_back(16);
        end
        if (par == 2'd1 || par == 2'd2) begin
          p = int'(^md) ^ (par == 2'd2 ? 1 : 0);
          seg_lvl.push_back(p); seg_len.push_back(16);
        end
        seg_lvl.push_back(1);
        seg_len.push_back(st == 2'd0 ? 16 : (st == 2'd1 ? 24 : 32));
        m_full = 0; m_sync = 0;
      end else if (wr_en && !m_full) begin
        m_full = 1; m_data = wr_data; m_sync = 0;
      end else if (m_full && m_sync < SYNC) begin
        m_sync++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, txd, seg_len.size() > 0 ? logic'(seg_lvl[0] != 0) : 1'b1, "txd");
      check(cur_req, empty, !m_full, "thr_empty");
      check(cur_req, busy, seg_len.size() > 0, "busy");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put(logic [7:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic wait_empty();
    while (!empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || !empty) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frame(string req, logic [7:0] d, logic [1:0] w, logic [1:0] s, logic [1:0] pr);
    cur_req = req;
    @(negedge clk);
    wl <= w; st <= s; par <= pr;
    put(d);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", txd, 1'b1, "txd");
    check("R1", empty, 1'b1, "thr_empty");
    check("R1", busy, 1'b0, "busy");
    rst_n <= 1'b1;
    repeat (2) @(negedge clk);

    frame("R2", 8'hA5, 2'd3, 2'd0, 2'd0);
    frame("R2", 8'h3C, 2'd3, 2'd0, 2'd0);
    for (int w = 0; w < 4; w++) frame("R3", 8'hFF, 2'(w), 2'd0, 2'd0);
    frame("R3", 8'hE0, 2'd0, 2'd0, 2'd1);
    for (int p = 0; p < 4; p++) begin
      frame("R4", 8'h96, 2'd3, 2'd0, 2'(p));
      frame("R4", 8'h07, 2'd1, 2'd0, 2'(p));
    end
    for (int s = 0; s < 4; s++) frame("R5", 8'h55, 2'd2, 2'(s), 2'd2);

    // R6: write while full is ignored
    cur_req = "R6";
    @(negedge clk);
    wl <= 2'd3; st <= 2'd0; par <= 2'd0;
    wr_en <= 1'b1; wr_data <= 8'h11;
    @(negedge clk);
    wr_data <= 8'hEE;
    @(negedge clk);
    wr_en <= 1'b0;
    check("R6", empty, 1'b0, "thr_empty after ignored write");
    wait_idle();

    // R7/R8: back-to-back words at shifting tick phases
    for (int k = 0; k < 6; k++) begin
      cur_req = (k % 2 == 0) ? "R7" : "R8";
      put(8'(8'h21 * (k + 1)));
      wait_empty();
      repeat (k) @(negedge clk);
      put(8'(8'h9A + k));
    end
    wait_idle();

    // R9: settings changed mid-frame do not affect the frame
    cur_req = "R9";
    @(negedge clk);
    wl <= 2'd3; st <= 2'd1; par <= 2'd1;
    put(8'hC3);
    repeat (60) @(negedge clk);
    wl <= 2'd0; st <= 2'd2; par <= 2'd2;
    wait_idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule